// File: doc/BRIEF.md
# Monitor Load-Detect Sequencer

This block decides whether an analog monitor is attached to a video DAC output by running a fixed register sequence. On a start pulse it reads and keeps the output-routing register and the DAC-control register. It then powers the DAC up, switches the outputs off, waits a programmable number of cycles, turns the CRT path back on and writes a test-level word. Next it routes that test level to the output and waits a second interval. The sequencer then samples a comparator sense bit and removes the test routing. Last, it writes both saved registers back with their original values.

The block is the only master on a small register port with four selectable registers and a read latency of one cycle. It reports its verdict through a one-cycle done pulse and a present flag. The present flag keeps its value until a later run samples the comparator again. Software or a power-management controller starts the check and reads back only the verdict. It never sees the intermediate register values.

Top module: `mon_load_detect`

## Requirements
- R1: After reset, busy_o, done_o, present_o and reg_req_o are all low.
- R2: An accepted start first issues a read of the output register (reg_sel_o = 0) and then a read of the DAC-control register (reg_sel_o = 1), one per cycle. reg_rdata_i carries read data in the cycle after a read.
- R3: The first write goes to the DAC-control register. It writes the saved value with bit 16 (power-down) cleared and every other bit unchanged.
- R4: The next write puts the saved output value ANDed with 0x0000FEEE into the output register.
- R5: The bus stays idle for a settle interval of max(settle_len_i, 1) cycles. The next write then puts (saved output AND 0x0000FEEE) OR 0x1 into the output register, exactly max(settle_len_i,1)+1 cycles after the previous write.
- R6: The next write puts the test-level word into the test-data register (reg_sel_o = 2). Bits 31:30 hold mode 2, and bits 29:20, 19:10 and 9:0 each hold 0x140, which gives 0x94050140.
- R7: The test-control register (reg_sel_o = 3) is read and then written with bit 12 set. After the second settle interval and one sense cycle it is written with bit 12 cleared and the other read bits unchanged. These two writes are max(settle_len_i,1)+2 cycles apart.
- R8: present_o takes the synchronised level of sense_i sampled in the cycle after the second settle interval, so it is high only if the comparator reads high.
- R9: The last two writes restore the saved output register and then the saved DAC-control register, both unchanged. Eleven bus operations are made in total.
- R10: busy_o is high from the cycle after an accepted start through the done_o cycle. done_o is a single-cycle pulse one cycle after the last restore write, and busy_o falls right after it.
- R11: A start pulse while busy_o is high is ignored: the run in progress is neither restarted nor extended, and no extra bus operations are made.
- R12: While busy_o is low, present_o keeps its value whatever sense_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| settle_len_i | input | SETTLE_W | Settle interval in cycles, latched at start (0 acts as 1) |
| sense_i | input | 1 | Comparator load-sense bit |
| reg_req_o | output | 1 | Register access request this cycle |
| reg_we_o | output | 1 | 1 = write, 0 = read |
| reg_sel_o | output | 2 | 0 output routing, 1 DAC control, 2 test data, 3 test control |
| reg_wdata_o | output | DATA_W | Write data |
| reg_rdata_i | input | DATA_W | Read data, valid the cycle after a read |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| present_o | output | 1 | Monitor-present verdict |

## Verification
The bench sweeps the settle length through zero, one and several cycles, both with and without a load, and uses saved register values that have the power-down, routing and CRT bits set in some runs and cleared in others. If a design treated a zero settle length as zero cycles or counted the interval off by one, the gaps between writes would come out wrong. If it rebuilt the restore values from masked copies, the last two writes would show bits that had been lost. If it cleared the routing bit with a hard-coded word, the neighbouring test-control bits would be lost. A start pulse issued in the middle of a settle interval would show up as a restarted sequence and extra bus operations. A comparator change after completion would move present_o in a design that does not hold its verdict.

// File: rtl/ld_pkg.sv
package ld_pkg;

   typedef enum logic [1:0] {
      RS_OUT   = 2'd0,
      RS_DAC   = 2'd1,
      RS_TDATA = 2'd2,
      RS_TCTL  = 2'd3
   } ld_reg_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RD_OUT,
      ST_RD_DAC,
      ST_DAC_ON,
      ST_OUT_OFF,
      ST_SETTLE1,
      ST_OUT_CRT,
      ST_TDATA,
      ST_RD_TCTL,
      ST_ROUTE_ON,
      ST_SETTLE2,
      ST_SENSE,
      ST_ROUTE_OFF,
      ST_OUT_RST,
      ST_DAC_RST,
      ST_DONE
   } ld_state_e;

endpackage

// File: rtl/ld_settle_timer.sv
module ld_settle_timer #(
   parameter int SETTLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic [SETTLE_W-1:0] len_i,
   output logic                run_o,
   output logic                expire_o
);

   localparam logic [SETTLE_W-1:0] ONE = {{(SETTLE_W-1){1'b0}}, 1'b1};

   logic [SETTLE_W-1:0] cnt_q;
   logic                run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load_i) begin
         cnt_q <= (len_i == '0) ? ONE : len_i;
         run_q <= 1'b1;
      end else if (run_q) begin
         if (cnt_q == ONE) run_q <= 1'b0;
         cnt_q <= cnt_q - ONE;
      end
   end

   assign run_o    = run_q;
   assign expire_o = run_q && (cnt_q == ONE);

   // R5: a running interval never sits at a zero count
   p_count_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q != '0));

endmodule

// File: rtl/ld_word_shaper.sv
module ld_word_shaper
   import ld_pkg::*;
#(
   parameter int                 DATA_W     = 32,
   parameter int                 LVL_W      = 10,
   parameter int                 MODE_W     = 2,
   parameter logic [MODE_W-1:0]  TEST_MODE  = 2'd2,
   parameter logic [LVL_W-1:0]   TEST_LEVEL = 10'h140,
   parameter int                 PD_BIT     = 16,
   parameter int                 ROUTE_BIT  = 12,
   parameter int                 CRT_BIT    = 0,
   parameter logic [DATA_W-1:0]  OUT_KEEP   = 32'h0000_FEEE
) (
   input  ld_state_e          state_i,
   input  logic [DATA_W-1:0]  rdata_i,
   input  logic [DATA_W-1:0]  out_sav_i,
   input  logic [DATA_W-1:0]  dac_sav_i,
   input  logic [DATA_W-1:0]  tctl_sav_i,
   output logic [DATA_W-1:0]  wdata_o
);

   localparam int                LVL_CNT = 3;
   localparam int                USED_W  = LVL_CNT * LVL_W + MODE_W;
   localparam logic [DATA_W-1:0] BIT0    = {{(DATA_W-1){1'b0}}, 1'b1};
   localparam logic [DATA_W-1:0] PD_M    = BIT0 << PD_BIT;
   localparam logic [DATA_W-1:0] ROUTE_M = BIT0 << ROUTE_BIT;
   localparam logic [DATA_W-1:0] CRT_M   = BIT0 << CRT_BIT;

   logic [DATA_W-1:0] test_word;

   assign test_word[LVL_CNT*LVL_W +: MODE_W] = TEST_MODE;
   for (genvar g = 0; g < LVL_CNT; g++) begin : g_lvl
      assign test_word[g*LVL_W +: LVL_W] = TEST_LEVEL;
   end
   if (DATA_W > USED_W) begin : g_pad
      assign test_word[DATA_W-1:USED_W] = '0;
   end

   always_comb begin
      unique case (state_i)
         ST_DAC_ON:    wdata_o = rdata_i & ~PD_M;
         ST_OUT_OFF:   wdata_o = out_sav_i & OUT_KEEP;
         ST_OUT_CRT:   wdata_o = (out_sav_i & OUT_KEEP) | CRT_M;
         ST_TDATA:     wdata_o = test_word;
         ST_ROUTE_ON:  wdata_o = rdata_i | ROUTE_M;
         ST_ROUTE_OFF: wdata_o = tctl_sav_i & ~ROUTE_M;
         ST_OUT_RST:   wdata_o = out_sav_i;
         ST_DAC_RST:   wdata_o = dac_sav_i;
         default:      wdata_o = '0;
      endcase
   end

endmodule

// File: rtl/mon_load_detect.sv
module mon_load_detect
   import ld_pkg::*;
#(
   parameter int                 DATA_W     = 32,
   parameter int                 LVL_W      = 10,
   parameter int                 MODE_W     = 2,
   parameter logic [MODE_W-1:0]  TEST_MODE  = 2'd2,
   parameter logic [LVL_W-1:0]   TEST_LEVEL = 10'h140,
   parameter int                 SETTLE_W   = 16,
   parameter int                 SENSE_SYNC = 2,
   parameter int                 PD_BIT     = 16,
   parameter int                 ROUTE_BIT  = 12,
   parameter int                 CRT_BIT    = 0,
   parameter logic [DATA_W-1:0]  OUT_KEEP   = 32'h0000_FEEE
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [SETTLE_W-1:0] settle_len_i,
   input  logic                sense_i,
   output logic                reg_req_o,
   output logic                reg_we_o,
   output logic [1:0]          reg_sel_o,
   output logic [DATA_W-1:0]   reg_wdata_o,
   input  logic [DATA_W-1:0]   reg_rdata_i,
   output logic                busy_o,
   output logic                done_o,
   output logic                present_o
);

   // elaboration-time parameter checks
   if (DATA_W < 3 * LVL_W + MODE_W) begin : g_chk_w
      $error("test word does not fit the data width");
   end
   if (PD_BIT >= DATA_W || ROUTE_BIT >= DATA_W || CRT_BIT >= DATA_W) begin : g_chk_b
      $error("control bit position outside the data width");
   end
   if (SETTLE_W < 1 || SENSE_SYNC < 0) begin : g_chk_s
      $error("bad settle width or synchroniser depth");
   end

   ld_state_e           state_q, state_d;
   logic [SETTLE_W-1:0] settle_q;
   logic [DATA_W-1:0]   out_sav_q, dac_sav_q, tctl_sav_q;
   logic                present_q;
   logic                sense_s;
   logic                tmr_load, tmr_run, tmr_expire;
   ld_reg_e             sel;

   // comparator synchroniser: depth picked by parameter
   if (SENSE_SYNC == 0) begin : g_nosync
      assign sense_s = sense_i;
   end else begin : g_sync
      logic [SENSE_SYNC-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= SENSE_SYNC'({sh_q, sense_i});
      end
      assign sense_s = sh_q[SENSE_SYNC-1];
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:      if (start_i) state_d = ST_RD_OUT;
         ST_RD_OUT:    state_d = ST_RD_DAC;
         ST_RD_DAC:    state_d = ST_DAC_ON;
         ST_DAC_ON:    state_d = ST_OUT_OFF;
         ST_OUT_OFF:   state_d = ST_SETTLE1;
         ST_SETTLE1:   if (tmr_expire) state_d = ST_OUT_CRT;
         ST_OUT_CRT:   state_d = ST_TDATA;
         ST_TDATA:     state_d = ST_RD_TCTL;
         ST_RD_TCTL:   state_d = ST_ROUTE_ON;
         ST_ROUTE_ON:  state_d = ST_SETTLE2;
         ST_SETTLE2:   if (tmr_expire) state_d = ST_SENSE;
         ST_SENSE:     state_d = ST_ROUTE_OFF;
         ST_ROUTE_OFF: state_d = ST_OUT_RST;
         ST_OUT_RST:   state_d = ST_DAC_RST;
         ST_DAC_RST:   state_d = ST_DONE;
         ST_DONE:      state_d = ST_IDLE;
         default:      state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         settle_q   <= '0;
         out_sav_q  <= '0;
         dac_sav_q  <= '0;
         tctl_sav_q <= '0;
         present_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start_i) settle_q   <= settle_len_i;
         if (state_q == ST_RD_DAC)          out_sav_q  <= reg_rdata_i;
         if (state_q == ST_DAC_ON)          dac_sav_q  <= reg_rdata_i;
         if (state_q == ST_ROUTE_ON)        tctl_sav_q <= reg_rdata_i;
         if (state_q == ST_SENSE)           present_q  <= sense_s;
      end
   end

   assign tmr_load = (state_q == ST_OUT_OFF) || (state_q == ST_ROUTE_ON);

   ld_settle_timer #(.SETTLE_W(SETTLE_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (tmr_load),
      .len_i    (settle_q),
      .run_o    (tmr_run),
      .expire_o (tmr_expire)
   );

   always_comb begin
      reg_req_o = 1'b1;
      reg_we_o  = 1'b1;
      sel       = RS_OUT;
      unique case (state_q)
         ST_RD_OUT:    reg_we_o = 1'b0;
         ST_RD_DAC:    begin reg_we_o = 1'b0; sel = RS_DAC; end
         ST_DAC_ON:    sel = RS_DAC;
         ST_OUT_OFF:   sel = RS_OUT;
         ST_OUT_CRT:   sel = RS_OUT;
         ST_TDATA:     sel = RS_TDATA;
         ST_RD_TCTL:   begin reg_we_o = 1'b0; sel = RS_TCTL; end
         ST_ROUTE_ON:  sel = RS_TCTL;
         ST_ROUTE_OFF: sel = RS_TCTL;
         ST_OUT_RST:   sel = RS_OUT;
         ST_DAC_RST:   sel = RS_DAC;
         default:      begin reg_req_o = 1'b0; reg_we_o = 1'b0; end
      endcase
   end

   assign reg_sel_o = sel;

   ld_word_shaper #(
      .DATA_W(DATA_W), .LVL_W(LVL_W), .MODE_W(MODE_W),
      .TEST_MODE(TEST_MODE), .TEST_LEVEL(TEST_LEVEL),
      .PD_BIT(PD_BIT), .ROUTE_BIT(ROUTE_BIT), .CRT_BIT(CRT_BIT),
      .OUT_KEEP(OUT_KEEP)
   ) u_shaper (
      .state_i    (state_q),
      .rdata_i    (reg_rdata_i),
      .out_sav_i  (out_sav_q),
      .dac_sav_i  (dac_sav_q),
      .tctl_sav_i (tctl_sav_q),
      .wdata_o    (reg_wdata_o)
   );

   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = (state_q == ST_DONE);
   assign present_o = present_q;

   p_first_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (reg_req_o && !reg_we_o && reg_sel_o == 2'd0));

   p_quiet_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_run |-> !reg_req_o);

   p_done_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

   p_busy_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);

   p_present_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |=> $stable(present_o));

endmodule

// File: tb/test_mon_load_detect.sv
module test_mon_load_detect;

   localparam int DW = 32;
   localparam int SW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [SW-1:0] settle = '0;
   logic          sense = 1'b0;
   logic          req, we, busy, done, present;
   logic [1:0]    sel;
   logic [DW-1:0] wdata;
   logic [DW-1:0] rdata = '0;

   always #2 clk = ~clk;

   mon_load_detect i_mon_load_detect (
      .clk(clk), .rst_n(rst_n), .start_i(start), .settle_len_i(settle),
      .sense_i(sense), .reg_req_o(req), .reg_we_o(we), .reg_sel_o(sel),
      .reg_wdata_o(wdata), .reg_rdata_i(rdata), .busy_o(busy),
      .done_o(done), .present_o(present)
   );

   // register slave model with operation log
   logic [DW-1:0] regs [4];
   logic [DW-1:0] pre  [4];
   logic          arm = 1'b0;
   int            cyc = 0;
   int            nops = 0;
   logic          op_we  [32];
   logic [1:0]    op_sel [32];
   logic [DW-1:0] op_dat [32];
   int            op_cyc [32];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (arm) begin
         for (int i = 0; i < 4; i++) regs[i] <= pre[i];
         nops <= 0;
      end else if (req) begin
         if (nops < 32) begin
            op_we[nops]  <= we;
            op_sel[nops] <= sel;
            op_dat[nops] <= we ? wdata : regs[sel];
            op_cyc[nops] <= cyc;
         end
         nops <= nops + 1;
         if (we) regs[sel] <= wdata;
         else    rdata <= regs[sel];
      end
   end

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string req_tag,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
      end
   endtask

   task automatic expect_op(input int k, input logic ewe, input logic [1:0] esel,
                            input logic [DW-1:0] edat, input string req_tag);
      chk(op_we[k] == ewe && op_sel[k] == esel && op_dat[k] == edat, req_tag,
          {op_we[k], 1'b0, op_sel[k], op_dat[k][27:0]},
          {ewe, 1'b0, esel, edat[27:0]});
      if (op_dat[k] != edat) chk(1'b0, req_tag, op_dat[k], edat);
   endtask

   localparam logic [DW-1:0] KEEP  = 32'h0000_FEEE;
   localparam logic [DW-1:0] TWORD = (32'd2 << 30) | (32'h140 << 20) | (32'h140 << 10) | 32'h140;

   task automatic run_case(input logic [DW-1:0] o0, input logic [DW-1:0] d0,
                           input logic [DW-1:0] t0, input int n, input bit ld,
                           input bit mid_start);
      int ne, c0, cd, wd;
      bit busy_ok;
      ne = (n == 0) ? 1 : n;
      @(negedge clk);
      pre[0] = o0; pre[1] = d0; pre[2] = 32'hDEAD_0000; pre[3] = t0;
      arm = 1'b1; settle = SW'(n); sense = ld;
      @(negedge clk);
      arm = 1'b0;
      repeat (4) @(negedge clk);
      c0 = cyc;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      busy_ok = 1'b1;
      wd = 0;
      if (mid_start) begin
         repeat (5) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done && wd < 2000) begin
         if (!busy) busy_ok = 1'b0;
         @(negedge clk);
         wd++;
      end
      chk(wd < 2000, "R10 watchdog", 32'(wd), 32'd2000);
      cd = cyc;
      chk(busy_ok && busy, "R10 busy through run", {31'd0, busy_ok}, 32'd1);
      chk(nops == 11, "R9 op count", 32'(nops), 32'd11);
      // R2 save reads
      expect_op(0, 1'b0, 2'd0, o0, "R2 read output");
      expect_op(1, 1'b0, 2'd1, d0, "R2 read dac");
      chk(op_cyc[0] == c0 + 1, "R2 first op cycle", 32'(op_cyc[0]), 32'(c0 + 1));
      expect_op(2, 1'b1, 2'd1, d0 & ~(32'd1 << 16), "R3 dac power on");
      expect_op(3, 1'b1, 2'd0, o0 & KEEP, "R4 outputs off");
      expect_op(4, 1'b1, 2'd0, (o0 & KEEP) | 32'd1, "R5 crt on");
      chk(op_cyc[4] - op_cyc[3] == ne + 1, "R5 settle gap",
          32'(op_cyc[4] - op_cyc[3]), 32'(ne + 1));
      expect_op(5, 1'b1, 2'd2, TWORD, "R6 test word");
      expect_op(6, 1'b0, 2'd3, t0, "R7 read test ctl");
      expect_op(7, 1'b1, 2'd3, t0 | (32'd1 << 12), "R7 route on");
      expect_op(8, 1'b1, 2'd3, t0 & ~(32'd1 << 12), "R7 route off");
      chk(op_cyc[8] - op_cyc[7] == ne + 2, "R7 route gap",
          32'(op_cyc[8] - op_cyc[7]), 32'(ne + 2));
      expect_op(9, 1'b1, 2'd0, o0, "R9 restore output");
      expect_op(10, 1'b1, 2'd1, d0, "R9 restore dac");
      chk(cd == op_cyc[10] + 1, "R10 done timing", 32'(cd), 32'(op_cyc[10] + 1));
      chk(present == ld, "R8 present", {31'd0, present}, {31'd0, ld});
      @(negedge clk);
      chk(!busy && !done, "R10 done single pulse", {30'd0, busy, done}, 32'd0);
      sense = ~ld;
      repeat (8) @(negedge clk);
      chk(present == ld, "R12 present held", {31'd0, present}, {31'd0, ld});
      chk(nops == 11 && !busy, "R11 no extra ops", 32'(nops), 32'd11);
   endtask

   initial begin
      for (int i = 0; i < 4; i++) pre[i] = '0;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !present && !req, "R1 reset state",
          {28'd0, busy, done, present, req}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && !done && !present && !req, "R1 idle after reset",
          {28'd0, busy, done, present, req}, 32'd0);
      for (int n = 0; n < 6; n++) begin
         for (int ld = 0; ld < 2; ld++) begin
            logic [DW-1:0] o0, d0, t0;
            o0 = (32'h1357_9BDF * (n * 2 + ld + 1)) ^ ((ld != 0) ? 32'hFFFF_FFFF : 32'h0001_1111);
            d0 = 32'hA5A5_0000 ^ (32'(n) << 16) ^ 32'(ld * 32'h0001_F00F);
            t0 = (ld != 0) ? 32'hFFFF_FFFF : 32'h0000_2000 ^ 32'(n);
            run_case(o0, d0, t0, n, ld[0], 1'b0);
         end
      end
      // R11: start pulse during the first settle interval
      run_case(32'hFFFF_FFFF, 32'h0001_0000, 32'h0000_1000, 4, 1'b1, 1'b1);
      run_case(32'h0000_0000, 32'hFFFE_FFFF, 32'hFFFF_EFFF, 3, 1'b0, 1'b1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #400000;
      n_chk++;
      n_bad++;
      $display("FAIL R10 global watchdog actual=%0d expected<%0d", cyc, 100000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule